// File: doc/BRIEF.md
# Bank-Aware Write Speed Scheduler

This block schedules write-backs into a banked resistive main memory whose cells can be programmed at two speeds. A normal write is fast. A slow write takes three times as long but wears the cell far less. The scheduler gives a write the slow speed only when nothing else is waiting for the same bank. A lone write therefore uses the bank's idle time to save endurance, and a bank with a backlog keeps its full throughput.

Regular write-backs enter a shared, age-ordered queue. Write-backs that are issued early, before eviction, enter a separate queue that holds the lowest priority. These early writes are always slow. They never count toward draining, and they reach a bank only when that bank has nothing better to do. When the regular queue fills past a high mark, the block enters a drain state. In that state every regular write is forced to normal speed until the queue falls to a low mark.

Each command leaves on a valid/ready channel that carries the bank, the address and a speed bit. A per-bank countdown models how long the bank stays busy, and no command is offered to a busy bank.

Top module: `wr_speed_sched`

## Requirements
- R1: The regular queue holds 32 entries and the early queue holds 8. `wr_ready` is low exactly when the regular queue is full, and `egr_ready` is low exactly when the early queue is full.
- R2: A regular write is issued with `cmd_slow`=1 (slow) when it is the only regular entry queued for its bank and the block is not draining.
- R3: A regular write is issued with `cmd_slow`=0 (normal) when two or more regular entries are queued for its bank.
- R4: After a command is accepted, `bank_busy[bank]` stays high for exactly NORM_CYC cycles after a normal write, or 3*NORM_CYC cycles after a slow write. No command is offered for a busy bank.
- R5: Among regular entries whose banks are idle, the oldest one is offered first.
- R6: An early write is offered only when no regular entry is eligible, its bank is idle and no regular entry is queued for that bank. It is always slow. Early entries are served oldest first.
- R7: An early write whose bank and address match a regular entry that is queued, or arriving in the same cycle, is accepted and discarded.
- R8: `drain_mode` rises the cycle after the regular queue holds 28 or more entries. It falls the cycle after the queue holds 16 or fewer. While it is high, every regular write is issued with `cmd_slow`=0.
- R9: After reset, both queues are empty, all banks are idle, `cmd_valid`=0, `drain_mode`=0, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Regular write-back request valid |
| wr_ready | output | 1 | Regular queue has room |
| wr_bank | input | 4 | Target bank of regular write |
| wr_addr | input | 16 | Address of regular write within the bank |
| egr_valid | input | 1 | Early write-back request valid |
| egr_ready | output | 1 | Early queue has room |
| egr_bank | input | 4 | Target bank of early write |
| egr_addr | input | 16 | Address of early write |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Memory accepts the command |
| cmd_bank | output | 4 | Bank of offered command |
| cmd_addr | output | 16 | Address of offered command |
| cmd_slow | output | 1 | 1 = slow write, 0 = normal write |
| bank_busy | output | 16 | Per-bank busy flag from the countdown model |
| drain_mode | output | 1 | Regular queue is being drained |

## Verification
The hardest state to reach is the drain window. The regular queue must be driven past its high mark while nothing leaves it. Then a long series of issues has to be observed until the queue falls to the low mark, and every one of those issues must be seen at normal speed. The bench holds `cmd_ready` low while it fills the queue. It puts one lone write at the head, so that only the drain can explain a normal speed for it. It then stacks the rest on a single bank, so that pops are spaced by the busy timer and can be counted one by one until `drain_mode` falls.

// File: rtl/wss_pkg.sv
package wss_pkg;
   typedef enum logic {
      SPD_NORM = 1'b0,
      SPD_SLOW = 1'b1
   } spd_e;
endpackage

// File: rtl/wss_regq.sv
module wss_regq #(
   parameter int DEPTH = 32,
   parameter int NB    = 16,
   parameter int AW    = 16,
   parameter int HI    = 28,
   parameter int LO    = 16,
   localparam int BW   = $clog2(NB),
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [BW-1:0] push_bank,
   input  logic [AW-1:0] push_addr,
   output logic          full,
   input  logic [NB-1:0] bank_idle,
   input  logic          pop,
   output logic          sel_valid,
   output logic [BW-1:0] sel_bank,
   output logic [AW-1:0] sel_addr,
   output logic [CW-1:0] bank_cnt [NB],
   input  logic [BW-1:0] probe_bank,
   input  logic [AW-1:0] probe_addr,
   output logic          probe_hit,
   output logic          drain
);
   logic [BW-1:0] q_bank [DEPTH];
   logic [AW-1:0] q_addr [DEPTH];
   logic [CW-1:0] cnt;
   logic [IW-1:0] sel_idx;

   // oldest eligible entry: lowest index whose bank is idle
   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (CW'(i) < cnt && bank_idle[q_bank[i]]) begin
            sel_valid = 1'b1;
            sel_idx   = IW'(i);
         end
      end
   end
   assign sel_bank = q_bank[sel_idx];
   assign sel_addr = q_addr[sel_idx];
   assign full     = (cnt == CW'(DEPTH));

   always_comb begin
      for (int b = 0; b < NB; b++) bank_cnt[b] = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CW'(i) < cnt) bank_cnt[q_bank[i]] = bank_cnt[q_bank[i]] + 1'b1;
      end
   end

   always_comb begin
      probe_hit = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CW'(i) < cnt && q_bank[i] == probe_bank && q_addr[i] == probe_addr)
            probe_hit = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         drain <= 1'b0;
      end else begin
         cnt <= cnt - CW'(pop) + CW'(push);
         if (cnt >= CW'(HI))      drain <= 1'b1;
         else if (cnt <= CW'(LO)) drain <= 1'b0;
      end
   end

   // compact over the popped slot, then append at the new tail
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
         if (pop && IW'(i) >= sel_idx) begin
            q_bank[i] <= q_bank[i+1];
            q_addr[i] <= q_addr[i+1];
         end
      end
      if (push) begin
         q_bank[IW'(cnt - CW'(pop))] <= push_bank;
         q_addr[IW'(cnt - CW'(pop))] <= push_addr;
      end
   end

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop)) else $error("regular queue overflow");
   p_pop_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> sel_valid) else $error("pop without eligible entry");
   p_drain_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drain) |-> $past(cnt) >= CW'(HI)) else $error("drain entered early");
   p_drain_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drain) |-> $past(cnt) <= CW'(LO)) else $error("drain left early");
endmodule

// File: rtl/wss_eagerq.sv
module wss_eagerq #(
   parameter int DEPTH = 8,
   parameter int NB    = 16,
   parameter int AW    = 16,
   localparam int BW   = $clog2(NB),
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [BW-1:0] push_bank,
   input  logic [AW-1:0] push_addr,
   output logic          full,
   input  logic [NB-1:0] bank_ok,
   input  logic          pop,
   output logic          sel_valid,
   output logic [BW-1:0] sel_bank,
   output logic [AW-1:0] sel_addr
);
   logic [BW-1:0] q_bank [DEPTH];
   logic [AW-1:0] q_addr [DEPTH];
   logic [CW-1:0] cnt;
   logic [IW-1:0] sel_idx;

   always_comb begin
      sel_valid = 1'b0;
      sel_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (CW'(i) < cnt && bank_ok[q_bank[i]]) begin
            sel_valid = 1'b1;
            sel_idx   = IW'(i);
         end
      end
   end
   assign sel_bank = q_bank[sel_idx];
   assign sel_addr = q_addr[sel_idx];
   assign full     = (cnt == CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt - CW'(pop) + CW'(push);
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
         if (pop && IW'(i) >= sel_idx) begin
            q_bank[i] <= q_bank[i+1];
            q_addr[i] <= q_addr[i+1];
         end
      end
      if (push) begin
         q_bank[IW'(cnt - CW'(pop))] <= push_bank;
         q_addr[IW'(cnt - CW'(pop))] <= push_addr;
      end
   end

   p_eager_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop)) else $error("early queue overflow");
endmodule

// File: rtl/wss_bank_timers.sv
module wss_bank_timers #(
   parameter int NB        = 16,
   parameter int NORM_CYC  = 38,
   parameter int SLOW_MULT = 3,
   localparam int BW       = $clog2(NB),
   localparam int TW       = $clog2(SLOW_MULT * NORM_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic [BW-1:0] issue_bank,
   input  logic          issue_slow,
   output logic [NB-1:0] busy
);
   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [TW-1:0] tmr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tmr <= '0;
         else if (issue && issue_bank == BW'(b))
            tmr <= issue_slow ? TW'(SLOW_MULT * NORM_CYC) : TW'(NORM_CYC);
         else if (tmr != '0)
            tmr <= tmr - 1'b1;
      end
      assign busy[b] = (tmr != '0);
   end

   p_issue_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !busy[issue_bank]) else $error("command issued to busy bank");
endmodule

// File: rtl/wr_speed_sched.sv
module wr_speed_sched #(
   parameter int NUM_BANKS = 16,
   parameter int ADDR_W    = 16,
   parameter int WQ_DEPTH  = 32,
   parameter int EQ_DEPTH  = 8,
   parameter int DRAIN_HI  = 28,
   parameter int DRAIN_LO  = 16,
   parameter int NORM_CYC  = 38,
   parameter int SLOW_MULT = 3,
   localparam int BW       = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_valid,
   output logic                 wr_ready,
   input  logic [BW-1:0]        wr_bank,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic                 egr_valid,
   output logic                 egr_ready,
   input  logic [BW-1:0]        egr_bank,
   input  logic [ADDR_W-1:0]    egr_addr,
   output logic                 cmd_valid,
   input  logic                 cmd_ready,
   output logic [BW-1:0]        cmd_bank,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic                 cmd_slow,
   output logic [NUM_BANKS-1:0] bank_busy,
   output logic                 drain_mode
);
   import wss_pkg::*;
   localparam int CW = $clog2(WQ_DEPTH + 1);

   if ((1 << BW) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two");
   end
   if (DRAIN_LO >= DRAIN_HI || DRAIN_HI > WQ_DEPTH) begin : g_bad_marks
      $error("drain marks must satisfy LO < HI <= WQ_DEPTH");
   end
   if (SLOW_MULT < 2 || NORM_CYC < 1) begin : g_bad_lat
      $error("latency parameters out of range");
   end

   logic                 rq_full, rq_sel_valid, rq_hit, rq_pop;
   logic [BW-1:0]        rq_sel_bank;
   logic [ADDR_W-1:0]    rq_sel_addr;
   logic [CW-1:0]        rq_cnt [NUM_BANKS];
   logic                 eq_full, eq_sel_valid, eq_pop, eq_push;
   logic [BW-1:0]        eq_sel_bank;
   logic [ADDR_W-1:0]    eq_sel_addr;
   logic [NUM_BANKS-1:0] eq_ok;
   logic                 wr_push, egr_accept, egr_dup, from_eager, fire;
   spd_e                 speed;

   assign wr_ready   = !rq_full;
   assign egr_ready  = !eq_full;
   assign wr_push    = wr_valid && wr_ready;
   assign egr_accept = egr_valid && egr_ready;
   assign egr_dup    = rq_hit || (wr_push && wr_bank == egr_bank && wr_addr == egr_addr);
   assign eq_push    = egr_accept && !egr_dup;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ok
      assign eq_ok[b] = !bank_busy[b] && (rq_cnt[b] == '0);
   end

   wss_regq #(.DEPTH(WQ_DEPTH), .NB(NUM_BANKS), .AW(ADDR_W),
              .HI(DRAIN_HI), .LO(DRAIN_LO)) u_regq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_push), .push_bank(wr_bank), .push_addr(wr_addr), .full(rq_full),
      .bank_idle(~bank_busy), .pop(rq_pop),
      .sel_valid(rq_sel_valid), .sel_bank(rq_sel_bank), .sel_addr(rq_sel_addr),
      .bank_cnt(rq_cnt), .probe_bank(egr_bank), .probe_addr(egr_addr),
      .probe_hit(rq_hit), .drain(drain_mode));

   wss_eagerq #(.DEPTH(EQ_DEPTH), .NB(NUM_BANKS), .AW(ADDR_W)) u_eagerq (
      .clk(clk), .rst_n(rst_n),
      .push(eq_push), .push_bank(egr_bank), .push_addr(egr_addr), .full(eq_full),
      .bank_ok(eq_ok), .pop(eq_pop),
      .sel_valid(eq_sel_valid), .sel_bank(eq_sel_bank), .sel_addr(eq_sel_addr));

   // regular work always wins; early work fills idle banks only
   assign from_eager = !rq_sel_valid && eq_sel_valid;
   assign cmd_valid  = rq_sel_valid || eq_sel_valid;
   assign cmd_bank   = from_eager ? eq_sel_bank : rq_sel_bank;
   assign cmd_addr   = from_eager ? eq_sel_addr : rq_sel_addr;

   always_comb begin
      if (from_eager)                              speed = SPD_SLOW;
      else if (!drain_mode && rq_cnt[rq_sel_bank] == CW'(1)) speed = SPD_SLOW;
      else                                         speed = SPD_NORM;
   end
   assign cmd_slow = (speed == SPD_SLOW);

   assign fire   = cmd_valid && cmd_ready;
   assign rq_pop = fire && !from_eager;
   assign eq_pop = fire && from_eager;

   wss_bank_timers #(.NB(NUM_BANKS), .NORM_CYC(NORM_CYC), .SLOW_MULT(SLOW_MULT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .issue(fire), .issue_bank(cmd_bank),
      .issue_slow(cmd_slow), .busy(bank_busy));

   p_eager_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !rq_sel_valid) |-> (rq_cnt[cmd_bank] == '0 && cmd_slow))
      else $error("early write offered while regular work pending");
endmodule

// File: tb/wr_speed_sched_bench.sv
`timescale 1ns/1ps
module wr_speed_sched_bench;
   localparam int NB = 16, AW = 16, NORM = 38, SLOW = 3 * NORM;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_valid = 0, egr_valid = 0, cmd_ready = 0;
   logic [3:0] wr_bank = 0, egr_bank = 0;
   logic [AW-1:0] wr_addr = 0, egr_addr = 0;
   logic wr_ready, egr_ready, cmd_valid, cmd_slow, drain_mode;
   logic [3:0] cmd_bank;
   logic [AW-1:0] cmd_addr;
   logic [NB-1:0] bank_busy;
   int errs = 0, checks = 0, cyc = 0;

   always #2 clk = ~clk;

   wr_speed_sched u_wr_speed_sched (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank), .wr_addr(wr_addr),
      .egr_valid(egr_valid), .egr_ready(egr_ready), .egr_bank(egr_bank), .egr_addr(egr_addr),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .cmd_slow(cmd_slow), .bank_busy(bank_busy),
      .drain_mode(drain_mode));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_wr(input int b, input int a);
      wr_valid = 1; wr_bank = 4'(b); wr_addr = AW'(a);
      @(negedge clk); wr_valid = 0;
   endtask

   task automatic push_eg(input int b, input int a);
      egr_valid = 1; egr_bank = 4'(b); egr_addr = AW'(a);
      @(negedge clk); egr_valid = 0;
   endtask

   task automatic fire();
      cmd_ready = 1; @(negedge clk); cmd_ready = 0;
   endtask

   task automatic busy_len(input int b, output int n);
      n = 0;
      while (bank_busy[b] && n < 1000) begin n++; @(negedge clk); end
   endtask

   task automatic flush();
      cmd_ready = 1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (!cmd_valid && bank_busy == '0) break;
      end
      cmd_ready = 0;
   endtask

   task automatic t_reset();
      chk("R9 cmd_valid", cmd_valid, 0);
      chk("R9 drain_mode", drain_mode, 0);
      chk("R9 bank_busy", int'(bank_busy), 0);
      chk("R9 wr_ready", wr_ready, 1);
      chk("R9 egr_ready", egr_ready, 1);
   endtask

   task automatic t_single();
      int n;
      push_wr(3, 'h100);
      chk("R2 single valid", cmd_valid, 1);
      chk("R2 single bank", cmd_bank, 3);
      chk("R2 single addr", cmd_addr, 'h100);
      chk("R2 single slow", cmd_slow, 1);
      fire();
      busy_len(3, n);
      chk("R4 slow busy length", n, SLOW);
      flush();
   endtask

   task automatic t_pair();
      int n;
      push_wr(5, 'h10);
      push_wr(5, 'h11);
      chk("R3 pair addr", cmd_addr, 'h10);
      chk("R3 pair normal", cmd_slow, 0);
      fire();
      chk("R4 no cmd to busy bank", cmd_valid, 0);
      busy_len(5, n);
      chk("R4 normal busy length", n, NORM);
      chk("R2 remaining valid", cmd_valid, 1);
      chk("R2 remaining addr", cmd_addr, 'h11);
      chk("R2 remaining slow", cmd_slow, 1);
      flush();
   endtask

   task automatic t_oldest();
      push_wr(1, 'h21);
      push_wr(2, 'h22);
      chk("R5 oldest first bank", cmd_bank, 1);
      fire();
      chk("R5 next bank", cmd_bank, 2);
      flush();
   endtask

   task automatic t_eager();
      int n;
      push_eg(11, 'h20);
      push_wr(10, 'h30);
      chk("R6 regular before early", cmd_bank, 10);
      fire();
      chk("R6 early bank", cmd_bank, 11);
      chk("R6 early addr", cmd_addr, 'h20);
      chk("R6 early slow", cmd_slow, 1);
      flush();
      push_wr(12, 'h40);
      push_eg(12, 'h41);
      chk("R6 same bank regular first", cmd_addr, 'h40);
      fire();
      busy_len(12, n);
      chk("R6 early after bank frees", cmd_addr, 'h41);
      chk("R6 early after bank slow", cmd_slow, 1);
      flush();
   endtask

   task automatic t_drop();
      int n;
      push_wr(9, 'h55);
      push_eg(9, 'h55);
      push_eg(9, 'h56);
      fire();
      busy_len(9, n);
      chk("R7 survivor addr", cmd_addr, 'h56);
      fire();
      busy_len(9, n);
      chk("R7 duplicate discarded", cmd_valid, 0);
      flush();
   endtask

   task automatic t_eager_full();
      for (int i = 0; i < 7; i++) push_eg(i, 'h300 + i);
      chk("R1 early room at 7", egr_ready, 1);
      push_eg(7, 'h307);
      chk("R1 early full at 8", egr_ready, 0);
      flush();
   endtask

   task automatic t_drain();
      int pops, slows, g;
      push_wr(15, 'h0);
      for (int i = 0; i < 26; i++) push_wr(0, i + 1);
      @(negedge clk);
      chk("R8 no drain at 27", drain_mode, 0);
      push_wr(0, 'h100);
      @(negedge clk);
      chk("R8 drain at 28", drain_mode, 1);
      for (int i = 0; i < 3; i++) push_wr(0, 'h200 + i);
      chk("R1 room at 31", wr_ready, 1);
      push_wr(0, 'h203);
      chk("R1 full at 32", wr_ready, 0);
      chk("R8 lone write forced normal bank", cmd_bank, 15);
      chk("R8 lone write forced normal", cmd_slow, 0);
      pops = 0; slows = 0; g = 0;
      cmd_ready = 1;
      while (drain_mode && g < 3000) begin
         if (cmd_valid) begin pops++; if (cmd_slow) slows++; end
         g++;
         @(negedge clk);
      end
      cmd_ready = 0;
      chk("R8 pops until drain ends", pops, 16);
      chk("R8 slow writes during drain", slows, 0);
      flush();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_single();
      t_pair();
      t_oldest();
      t_eager();
      t_drop();
      t_eager_full();
      t_drain();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule